// File: doc/BRIEF.md
# Sequential Shift-Add / Booth Multiplier

This block multiplies two N-bit operands over N clock cycles using one shared datapath. A mode input picks between unsigned multiplication, where each step conditionally adds the multiplicand and captures the carry, and signed two's-complement multiplication, where each step looks at the low multiplier bit and a trailing history bit to choose add, subtract or no change. Each cycle does one add-and-shift step on an accumulator, the multiplier register and one extra bit. In unsigned mode the extra bit is the carry. In signed mode it is the previous low multiplier bit.

A caller asserts `start_i` for one cycle while the block is idle. Operands and mode are captured on that edge. `busy_o` stays high for exactly N cycles. `done_o` pulses for one cycle when `busy_o` falls. From that cycle on, the 2N-bit result on `product_o` is valid. It holds until the next accepted start.

Top module: `shiftbooth_mult`

## Requirements
- R1: During and right after reset, `busy_o` is 0, `done_o` is 0 and `product_o` is all zeros.
- R2: A `start_i` high while `busy_o` is low is accepted. `busy_o` is high in the next cycle and stays high for exactly N consecutive cycles.
- R3: `done_o` is high for exactly one cycle: the first cycle in which `busy_o` is low again after an operation.
- R4: With `signed_i` = 0 at start, `product_o` at `done_o` is the unsigned product of `mcand_i` and `mplier_i` as 2N bits. For N=4, 6 times 14 gives 8'b0101_0100.
- R5: With `signed_i` = 1 at start, both operands are two's complement and `product_o` at `done_o` is their 2N-bit two's-complement product. For N=4, 7 times -6 (4'b1010) gives 8'b1101_0110. This includes the most negative operand on either side.
- R6: A `start_i` pulse while `busy_o` is high is ignored. The running operation keeps its operands, its timing and its result.
- R7: While idle and without an accepted start, `product_o` holds its last value.
- R8: Mode and operands are sampled only on the accepting edge. Changes to `signed_i`, `mcand_i` or `mplier_i` during an operation have no effect on its result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin a multiplication |
| signed_i | input | 1 | 1 = signed two's-complement mode, 0 = unsigned |
| mcand_i | input | N | Multiplicand |
| mplier_i | input | N | Multiplier |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle pulse when the result becomes valid |
| product_o | output | 2N | Result: accumulator concatenated with multiplier register |

## Verification
The bound checker checks the handshake on every cycle. Busy may only rise after a start. A busy run never exceeds N cycles. Done appears only after exactly N busy cycles and never twice in a row. The product stays frozen while idle. The arithmetic can only be shown by the bench's scenarios, which compare every result against an independent integer model. These cover every operand pair in both modes, the two worked examples, most-negative operands, and starts and mode changes injected mid-operation.

// File: rtl/smul_pkg.sv
`timescale 1ns/1ps
package smul_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_ADD  = 2'd1,
        ACT_SUB  = 2'd2
    } act_e;

    typedef enum logic {
        MODE_UNS = 1'b0,
        MODE_SGN = 1'b1
    } mode_e;

    typedef struct packed {
        act_e act;
        logic ext_next;
    } step_ctl_t;

    // Booth pair: low multiplier bit and trailing history bit
    function automatic act_e booth_pick(logic q0, logic qm1);
        act_e r;
        case ({q0, qm1})
            2'b10:   r = ACT_SUB;
            2'b01:   r = ACT_ADD;
            default: r = ACT_HOLD;
        endcase
        return r;
    endfunction

    function automatic act_e shift_add_pick(logic q0);
        return q0 ? ACT_ADD : ACT_HOLD;
    endfunction

endpackage

// File: rtl/smul_decode.sv
`timescale 1ns/1ps
module smul_decode
    import smul_pkg::*;
(
    input  mode_e     mode,
    input  logic      q0,
    input  logic      ext,
    output step_ctl_t ctl
);
    always_comb begin
        if (mode == MODE_SGN) begin
            ctl.act      = booth_pick(q0, ext);
            ctl.ext_next = q0;
        end else begin
            ctl.act      = shift_add_pick(q0);
            ctl.ext_next = 1'b0;   // carry flop is emptied by the shift
        end
    end
endmodule

// File: rtl/smul_addsub.sv
`timescale 1ns/1ps
module smul_addsub #(
    parameter int W = 5
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         en,
    input  logic         sub,
    output logic [W-1:0] sum
);
    logic [W-1:0] bx;
    logic [W-1:0] c;

    assign bx   = en ? (sub ? ~b : b) : '0;
    assign c[0] = en & sub;

    for (genvar i = 0; i < W; i++) begin : g_fa
        assign sum[i] = a[i] ^ bx[i] ^ c[i];
        if (i < W - 1) begin : g_cy
            assign c[i+1] = (a[i] & bx[i]) | (c[i] & (a[i] ^ bx[i]));
        end
    end
endmodule

// File: rtl/smul_step.sv
`timescale 1ns/1ps
module smul_step
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  mode_e        mode,
    input  logic [N-1:0] acc,
    input  logic [N-1:0] mq,
    input  logic         ext,
    input  logic [N-1:0] mcand,
    output logic [N-1:0] acc_n,
    output logic [N-1:0] mq_n,
    output logic         ext_n
);
    localparam int XW = N + 1;

    step_ctl_t     ctl;
    logic          sx;
    logic [XW-1:0] acc_x;
    logic [XW-1:0] mc_x;
    logic [XW-1:0] t;

    smul_decode u_dec (
        .mode (mode),
        .q0   (mq[0]),
        .ext  (ext),
        .ctl  (ctl)
    );

    // top bit is the carry in unsigned mode, the sign guard in signed mode
    assign sx    = (mode == MODE_SGN);
    assign acc_x = {sx & acc[N-1], acc};
    assign mc_x  = {sx & mcand[N-1], mcand};

    smul_addsub #(.W(XW)) u_add (
        .a   (acc_x),
        .b   (mc_x),
        .en  (ctl.act != ACT_HOLD),
        .sub (ctl.act == ACT_SUB),
        .sum (t)
    );

    assign acc_n = t[XW-1:1];
    assign mq_n  = {t[0], mq[N-1:1]};
    assign ext_n = ctl.ext_next;
endmodule

// File: rtl/smul_seq.sv
`timescale 1ns/1ps
module smul_seq #(
    parameter int N = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic load,
    output logic step,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] cnt;

    assign load = start & ~busy;
    assign step = busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            busy <= 1'b0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                cnt  <= CW'(N);
                busy <= 1'b1;
            end else if (step) begin
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/shiftbooth_mult.sv
`timescale 1ns/1ps
module shiftbooth_mult
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start_i,
    input  logic           signed_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);
    logic         load, step;
    mode_e        mode_q;
    logic [N-1:0] acc_q, mq_q, mc_q;
    logic         ext_q;
    logic [N-1:0] acc_n, mq_n;
    logic         ext_n;

    smul_seq #(.N(N)) u_seq (
        .clk   (clk),
        .rst   (rst),
        .start (start_i),
        .load  (load),
        .step  (step),
        .busy  (busy_o),
        .done  (done_o)
    );

    smul_step #(.N(N)) u_step (
        .mode  (mode_q),
        .acc   (acc_q),
        .mq    (mq_q),
        .ext   (ext_q),
        .mcand (mc_q),
        .acc_n (acc_n),
        .mq_n  (mq_n),
        .ext_n (ext_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            mq_q   <= '0;
            mc_q   <= '0;
            ext_q  <= 1'b0;
            mode_q <= MODE_UNS;
        end else if (load) begin
            acc_q  <= '0;
            mq_q   <= mplier_i;
            mc_q   <= mcand_i;
            ext_q  <= 1'b0;
            mode_q <= mode_e'(signed_i);
        end else if (step) begin
            acc_q <= acc_n;
            mq_q  <= mq_n;
            ext_q <= ext_n;
        end
    end

    assign product_o = {acc_q, mq_q};
endmodule

// File: rtl/smul_checker.sv
`timescale 1ns/1ps
module smul_checker #(
    parameter int N = 4
) (
    input logic           clk,
    input logic           rst,
    input logic           start_i,
    input logic           busy_o,
    input logic           done_o,
    input logic [2*N-1:0] product_o
);
    localparam int RW = $clog2(N + 2);
    logic [RW-1:0] run;

    always_ff @(posedge clk) begin
        if (rst)         run <= '0;
        else if (busy_o) run <= run + 1'b1;
        else             run <= '0;
    end

    assert_busy_from_start_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(start_i));

    assert_busy_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> (run < RW'(N)));

    assert_done_after_run_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (!busy_o && run == RW'(N)));

    assert_done_single_R3: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && !start_i) |=> $stable(product_o));
endmodule

bind shiftbooth_mult smul_checker #(.N(N)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .product_o (product_o)
);

// File: tb/shiftbooth_mult_tb_top.sv
`timescale 1ns/1ps
module shiftbooth_mult_tb_top;
    localparam int N = 4;
    localparam int P = 2 * N;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic         signed_i = 1'b0;
    logic [N-1:0] mcand_i = '0;
    logic [N-1:0] mplier_i = '0;
    logic         busy_o, done_o;
    logic [P-1:0] product_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    shiftbooth_mult #(.N(N)) dut_i (
        .clk (clk), .rst (rst), .start_i (start_i), .signed_i (signed_i),
        .mcand_i (mcand_i), .mplier_i (mplier_i),
        .busy_o (busy_o), .done_o (done_o), .product_o (product_o)
    );

    function automatic logic [P-1:0] ref_prod(logic [N-1:0] a, logic [N-1:0] b, logic s);
        longint x = longint'(a);
        longint y = longint'(b);
        if (s && a[N-1]) x = x - (longint'(1) <<< N);
        if (s && b[N-1]) y = y - (longint'(1) <<< N);
        return P'(x * y);
    endfunction

    task automatic check(bit ok, string tag, longint act, longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit           m_busy = 0, m_done = 0, m_sgn = 0;
    int           m_left = 0;
    logic [P-1:0] m_prod = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_left <= 0; m_prod <= '0;
        end else begin
            m_done <= 0;
            if (!m_busy && start_i) begin
                m_busy <= 1;
                m_left <= N;
                m_sgn  <= signed_i;
                m_prod <= ref_prod(mcand_i, mplier_i, signed_i);
            end else if (m_busy) begin
                m_left <= m_left - 1;
                if (m_left == 1) begin
                    m_busy <= 0;
                    m_done <= 1;
                end
            end
        end
    end

    // every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check(busy_o == m_busy, "R2 busy", longint'(busy_o), longint'(m_busy));
            check(done_o == m_done, "R3 done", longint'(done_o), longint'(m_done));
            if (m_done)
                check(product_o == m_prod, m_sgn ? "R5 signed product" : "R4 unsigned product",
                      longint'(product_o), longint'(m_prod));
            else if (!m_busy)
                check(product_o == m_prod, "R7 idle hold", longint'(product_o), longint'(m_prod));
        end
    end

    task automatic run_op(logic [N-1:0] a, logic [N-1:0] b, logic s);
        @(negedge clk);
        start_i = 1'b1; signed_i = s; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b0;
        repeat (N + 1) @(negedge clk);
    endtask

    // R6 and R8: disturb inputs while the operation runs
    task automatic run_disturbed(logic [N-1:0] a, logic [N-1:0] b, logic s);
        @(negedge clk);
        start_i = 1'b1; signed_i = s; mcand_i = a; mplier_i = b;
        @(negedge clk);
        start_i = 1'b1; signed_i = ~s; mcand_i = ~a; mplier_i = b + 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (N) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy_o == 1'b0, "R1 busy in reset", longint'(busy_o), 0);
        check(done_o == 1'b0, "R1 done in reset", longint'(done_o), 0);
        check(product_o == '0, "R1 product in reset", longint'(product_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check(product_o == '0, "R1 product after reset", longint'(product_o), 0);

        // R4 worked example: 6 x 14 = 84
        run_op(4'd6, 4'd14, 1'b0);
        check(product_o == 8'b0101_0100, "R4 6x14", longint'(product_o), 84);
        // R5 worked example: 7 x -6 = -42
        run_op(4'd7, 4'b1010, 1'b1);
        check(product_o == 8'b1101_0110, "R5 7x-6", longint'(product_o), 8'hD6);
        // R5 most negative corners
        run_op(4'b1000, 4'b1000, 1'b1);
        check(product_o == 8'd64, "R5 -8x-8", longint'(product_o), 64);
        run_op(4'b1000, 4'd7, 1'b1);
        check(product_o == 8'b1100_1000, "R5 -8x7", longint'(product_o), 8'hC8);
        // R4 max unsigned
        run_op(4'hF, 4'hF, 1'b0);
        check(product_o == 8'd225, "R4 15x15", longint'(product_o), 225);

        // R6 R8: ignored start and changed mode/operands mid-operation
        run_disturbed(4'd6, 4'd14, 1'b0);
        check(product_o == 8'd84, "R6 R8 disturbed unsigned", longint'(product_o), 84);
        run_disturbed(4'd7, 4'b1010, 1'b1);
        check(product_o == 8'hD6, "R6 R8 disturbed signed", longint'(product_o), 8'hD6);

        // R7: long idle
        repeat (10) @(negedge clk);
        check(product_o == 8'hD6, "R7 held", longint'(product_o), 8'hD6);

        // R4 R5 exhaustive, both modes (model compares each cycle)
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < (1 << N); a++)
                for (int b = 0; b < (1 << N); b++)
                    run_op(N'(a), N'(b), s[0]);

        // R2: start held high re-accepts right after done
        @(negedge clk);
        start_i = 1'b1; signed_i = 1'b0; mcand_i = 4'd3; mplier_i = 4'd5;
        repeat (2 * N + 3) @(negedge clk);
        start_i = 1'b0;
        repeat (N + 2) @(negedge clk);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule